// File: doc/BRIEF.md
# CAN Receive Frame Store

This block holds received CAN frames in a 64-byte circular byte store until a host has read them. A frame receiver upstream pushes each frame as a burst of bytes. The first byte of the burst is the frame-info byte. After the last byte, a one-cycle end strobe either keeps the frame or throws it away. Each frame takes only as many bytes as its format and data length need. As a result, many short frames fit where only a few long ones would.

The host sees only the oldest stored frame, through a fixed 13-address read window. It frees that frame with a release strobe, and can read the number of complete frames held. A frame that cannot fit in the free space is dropped, and a sticky overrun flag records the loss. The block also drives a buffer-status flag and a receive interrupt, which is that flag gated by an enable input. A controller-hold input, used while the CAN controller sits in its configuration state, empties the store.

Top module: `can_rx_store`

## Requirements
- R1: The store holds 64 bytes. Kept frames whose lengths add up to exactly 64 are all stored, and no overrun is flagged.
- R2: The frame-info byte encodes the frame as follows: bit 7 = 1 means extended format, bit 6 = 1 means remote frame, and bits 3:0 are the DLC. A frame occupies a header plus data bytes. The header is 3 bytes for standard format and 5 for extended. The data count is 0 for remote frames, otherwise min(DLC, 8). Bytes sent past that length are not stored.
- R3: A read of `rd_addr` 16 to 28 returns byte (`rd_addr` − 16) of the oldest stored frame, on `rd_data` one clock after the address is presented. Any other address returns 0x00.
- R4: `msg_count` rises by one when a frame is kept and stored, and falls by one on `cmd_release`. A release while the count is zero has no effect on the count or on what the window shows.
- R5: A kept frame whose length exceeds the free space at its first byte is not stored, and `overrun` is set at its end strobe. `overrun` stays set until `cmd_clr_ovr`. If a drop and a clear occur in the same cycle, the flag is set.
- R6: `buf_status` is 1 exactly when `msg_count` is non-zero. Both change on the same clock edge.
- R7: `rx_int` equals `buf_status` AND `rx_int_en` with no register in between. Clearing the enable drops it in the same cycle, and nothing else clears it while frames remain.
- R8: While `ctl_hold` is high, the following apply: the count, both pointers, the occupancy and `overrun` are cleared; a frame in progress is abandoned; incoming bytes and releases are ignored. The first frame after hold is read from the window.
- R9: A release moves the read position forward by the length of the oldest frame, wrapping modulo 64. The window then shows the next frame.
- R10: A frame ended with `wr_keep` = 0 changes neither the count, the free space nor `overrun`, even if it would not have fit.
- R11: The stored info byte carries the DLC exactly as received, including values 9 to 15.
- R12: A synchronous active-high `rst` clears the count, `buf_status`, `overrun`, `rx_int` and `rd_data`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| ctl_hold | input | 1 | Controller hold; empties the store while high |
| wr_valid | input | 1 | Frame byte valid |
| wr_sof | input | 1 | Marks the info byte that starts a frame |
| wr_data | input | 8 | Frame byte |
| wr_end | input | 1 | End strobe of a frame (in a cycle without `wr_valid`) |
| wr_keep | input | 1 | With `wr_end`: 1 keeps the frame, 0 discards it |
| rd_addr | input | 5 | Host read address |
| rd_data | output | 8 | Host read data, one cycle after `rd_addr` |
| cmd_release | input | 1 | Frees the oldest frame |
| cmd_clr_ovr | input | 1 | Clears the overrun flag |
| rx_int_en | input | 1 | Receive interrupt enable |
| msg_count | output | 5 | Number of complete frames stored |
| buf_status | output | 1 | At least one frame stored |
| overrun | output | 1 | Sticky frame-lost flag |
| rx_int | output | 1 | Receive interrupt |

## Verification
The main stimulus is a sweep over all 64 info-byte variants: both formats, data and remote frames, and every DLC. Each variant is stored ahead of a fixed follower frame. Reading the follower after a release shows whether the length rule sized that variant correctly. Because the 64 variants have different lengths, the read position wraps many times during the sweep. A fill to exactly 64 bytes, followed by one more small frame, separates correct free-space accounting from an off-by-one. Discarded frames that would and would not have fitted show that discard leaves no trace. A drop and a clear in the same cycle show which of the two wins. Zero-count releases, enable toggles, hold and reset each probe one control path on its own.

// File: rtl/can_rxs_pkg.sv
package can_rxs_pkg;
  localparam int BYTE_W    = 8;
  localparam int LEN_W     = 4;
  localparam int STD_HDR   = 3;
  localparam int EXT_HDR   = 5;
  localparam int MAX_DATA  = 8;
  localparam int MIN_FRAME = STD_HDR;
  localparam int MAX_FRAME = EXT_HDR + MAX_DATA;
  localparam int EXT_BIT   = 7;
  localparam int RTR_BIT   = 6;

  typedef logic [BYTE_W-1:0] byte_t;
  typedef logic [LEN_W-1:0]  flen_t;

  // Bytes a frame occupies in the store, derived from its info byte.
  function automatic flen_t frame_len(input byte_t info);
    flen_t hdr;
    flen_t dat;
    hdr = info[EXT_BIT] ? flen_t'(EXT_HDR) : flen_t'(STD_HDR);
    if (info[RTR_BIT])
      dat = '0;
    else if (info[3:0] > 4'(MAX_DATA))
      dat = flen_t'(MAX_DATA);
    else
      dat = info[3:0];
    return hdr + dat;
  endfunction
endpackage

// File: rtl/rxs_ram.sv
module rxs_ram #(
  parameter int DEPTH = 64,
  parameter int DW    = 8,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);
  logic [DW-1:0] mem [DEPTH];

  // One write port, one registered read port (read-old on collision).
  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    rdata <= mem[raddr];
  end
endmodule

// File: rtl/rxs_wr_ctrl.sv
module rxs_wr_ctrl
  import can_rxs_pkg::*;
#(
  parameter int DEPTH  = 64,
  localparam int AW    = $clog2(DEPTH),
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             hold,
  input  logic             wr_valid,
  input  logic             wr_sof,
  input  byte_t            wr_data,
  input  logic             wr_end,
  input  logic             wr_keep,
  input  logic [CNT_W-1:0] free_bytes,
  output logic             ram_we,
  output logic [AW-1:0]    ram_waddr,
  output byte_t            ram_wdata,
  output logic             commit,
  output flen_t            commit_len,
  output logic             drop_evt
);
  logic          active_q;
  logic          drop_q;
  flen_t         need_q;
  flen_t         idx_q;
  logic [AW-1:0] wptr_q;

  flen_t sof_need;
  logic  sof_fit;
  logic  take_sof;
  logic  take_body;

  always_comb begin
    sof_need   = frame_len(wr_data);
    sof_fit    = CNT_W'(sof_need) <= free_bytes;
    take_sof   = !hold && wr_valid && wr_sof;
    take_body  = !hold && wr_valid && !wr_sof && active_q && !drop_q && (idx_q < need_q);
    ram_we     = (take_sof && sof_fit) || take_body;
    ram_waddr  = take_sof ? wptr_q : wptr_q + AW'(idx_q);
    ram_wdata  = wr_data;
    commit     = !hold && wr_end && active_q && wr_keep && !drop_q;
    drop_evt   = !hold && wr_end && active_q && wr_keep && drop_q;
    commit_len = need_q;
  end

  always_ff @(posedge clk) begin
    if (rst || hold) begin
      active_q <= 1'b0;
      drop_q   <= 1'b0;
      need_q   <= '0;
      idx_q    <= '0;
      wptr_q   <= '0;
    end else begin
      if (take_sof) begin
        active_q <= 1'b1;
        drop_q   <= !sof_fit;
        need_q   <= sof_need;
        idx_q    <= flen_t'(1);
      end else if (wr_valid && active_q && idx_q < flen_t'(MAX_FRAME)) begin
        idx_q <= idx_q + flen_t'(1);
      end
      if (wr_end) active_q <= 1'b0;
      if (commit) wptr_q <= wptr_q + AW'(need_q);
    end
  end
endmodule

// File: rtl/rxs_len_fifo.sv
module rxs_len_fifo
  import can_rxs_pkg::*;
#(
  parameter int SLOTS = 21,
  localparam int IW   = $clog2(SLOTS),
  localparam int CW   = $clog2(SLOTS + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          hold,
  input  logic          push,
  input  flen_t         push_len,
  input  logic          pop_req,
  output flen_t         head_len,
  output logic          pop_ok,
  output logic [CW-1:0] count,
  output logic [CW-1:0] count_next
);
  flen_t         slot_q [SLOTS];
  logic [IW-1:0] hd_q;
  logic [IW-1:0] tl_q;
  logic [CW-1:0] cnt_q;
  logic          do_push;

  function automatic logic [IW-1:0] step(input logic [IW-1:0] i);
    return (i == IW'(SLOTS - 1)) ? '0 : i + IW'(1);
  endfunction

  always_comb begin
    pop_ok     = pop_req && !hold && (cnt_q != '0);
    do_push    = push && !hold && ((cnt_q != CW'(SLOTS)) || pop_ok);
    head_len   = slot_q[hd_q];
    count_next = hold ? '0 : cnt_q + CW'(do_push) - CW'(pop_ok);
    count      = cnt_q;
  end

  always_ff @(posedge clk) begin
    if (do_push) slot_q[tl_q] <= push_len;
  end

  always_ff @(posedge clk) begin
    if (rst || hold) begin
      hd_q  <= '0;
      tl_q  <= '0;
      cnt_q <= '0;
    end else begin
      if (do_push) tl_q <= step(tl_q);
      if (pop_ok)  hd_q <= step(hd_q);
      cnt_q <= count_next;
    end
  end
endmodule

// File: rtl/can_rx_store.sv
module can_rx_store
  import can_rxs_pkg::*;
#(
  parameter int DEPTH    = 64,
  parameter int ADDR_W   = 5,
  parameter int WIN_BASE = 16,
  localparam int PTR_W   = $clog2(DEPTH),
  localparam int CNT_W   = $clog2(DEPTH + 1),
  localparam int SLOTS   = DEPTH / MIN_FRAME,
  localparam int MSG_W   = $clog2(SLOTS + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ctl_hold,
  input  logic              wr_valid,
  input  logic              wr_sof,
  input  logic [7:0]        wr_data,
  input  logic              wr_end,
  input  logic              wr_keep,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [7:0]        rd_data,
  input  logic              cmd_release,
  input  logic              cmd_clr_ovr,
  input  logic              rx_int_en,
  output logic [MSG_W-1:0]  msg_count,
  output logic              buf_status,
  output logic              overrun,
  output logic              rx_int
);
  localparam int WIN_LEN = MAX_FRAME;

  logic [PTR_W-1:0]  rptr_q;
  logic [CNT_W-1:0]  used_q;
  logic [CNT_W-1:0]  used_next;
  logic [CNT_W-1:0]  free_bytes;
  logic              buf_status_q;
  logic              overrun_q;
  logic              win_q;

  logic              ram_we;
  logic [PTR_W-1:0]  ram_waddr;
  byte_t             ram_wdata;
  logic [PTR_W-1:0]  ram_raddr;
  byte_t             ram_rdata;
  logic              commit;
  flen_t             commit_len;
  logic              drop_evt;
  flen_t             head_len;
  logic              pop_ok;
  logic [MSG_W-1:0]  cnt;
  logic [MSG_W-1:0]  cnt_next;
  logic [ADDR_W-1:0] rd_off;
  logic              in_win;

  rxs_wr_ctrl #(.DEPTH(DEPTH)) u_wr (
    .clk(clk), .rst(rst), .hold(ctl_hold),
    .wr_valid(wr_valid), .wr_sof(wr_sof), .wr_data(wr_data),
    .wr_end(wr_end), .wr_keep(wr_keep), .free_bytes(free_bytes),
    .ram_we(ram_we), .ram_waddr(ram_waddr), .ram_wdata(ram_wdata),
    .commit(commit), .commit_len(commit_len), .drop_evt(drop_evt)
  );

  rxs_ram #(.DEPTH(DEPTH), .DW(BYTE_W)) u_ram (
    .clk(clk), .we(ram_we), .waddr(ram_waddr), .wdata(ram_wdata),
    .raddr(ram_raddr), .rdata(ram_rdata)
  );

  rxs_len_fifo #(.SLOTS(SLOTS)) u_len (
    .clk(clk), .rst(rst), .hold(ctl_hold),
    .push(commit), .push_len(commit_len), .pop_req(cmd_release),
    .head_len(head_len), .pop_ok(pop_ok),
    .count(cnt), .count_next(cnt_next)
  );

  // Host window onto the oldest frame.
  always_comb begin
    rd_off    = rd_addr - ADDR_W'(WIN_BASE);
    in_win    = (rd_addr >= ADDR_W'(WIN_BASE)) && (rd_off < ADDR_W'(WIN_LEN));
    ram_raddr = rptr_q + PTR_W'(rd_off);
  end

  // Occupancy bookkeeping.
  always_comb begin
    free_bytes = CNT_W'(DEPTH) - used_q;
    used_next  = used_q
               + (commit ? CNT_W'(commit_len) : '0)
               - (pop_ok ? CNT_W'(head_len)   : '0);
  end

  always_ff @(posedge clk) begin
    if (rst) win_q <= 1'b0;
    else     win_q <= in_win;
  end

  always_ff @(posedge clk) begin
    if (rst || ctl_hold) begin
      rptr_q       <= '0;
      used_q       <= '0;
      buf_status_q <= 1'b0;
      overrun_q    <= 1'b0;
    end else begin
      used_q       <= used_next;
      buf_status_q <= (cnt_next != '0);
      if (pop_ok) rptr_q <= rptr_q + PTR_W'(head_len);
      if (drop_evt)         overrun_q <= 1'b1;
      else if (cmd_clr_ovr) overrun_q <= 1'b0;
    end
  end

  assign rd_data    = win_q ? ram_rdata : '0;
  assign msg_count  = cnt;
  assign buf_status = buf_status_q;
  assign overrun    = overrun_q;
  assign rx_int     = buf_status_q && rx_int_en;
endmodule

// File: rtl/can_rxs_chk.sv
module can_rxs_chk #(
  parameter int DEPTH = 64,
  parameter int MSG_W = 5,
  parameter int CNT_W = 7
) (
  input logic             clk,
  input logic             rst,
  input logic             ctl_hold,
  input logic             cmd_clr_ovr,
  input logic             rx_int_en,
  input logic             wr_end,
  input logic             wr_keep,
  input logic [MSG_W-1:0] msg_count,
  input logic             buf_status,
  input logic             overrun,
  input logic             rx_int,
  input logic [CNT_W-1:0] used_bytes
);
  // R1
  used_bound_chk: assert property (@(posedge clk) disable iff (rst)
    used_bytes <= CNT_W'(DEPTH));

  // R4
  count_step_chk: assert property (@(posedge clk) disable iff (rst)
    !ctl_hold |=> (msg_count == $past(msg_count)) ||
                  (msg_count == $past(msg_count) + 1'b1) ||
                  (msg_count + 1'b1 == $past(msg_count)));

  // R5
  overrun_sticky_chk: assert property (@(posedge clk) disable iff (rst)
    overrun && !cmd_clr_ovr && !ctl_hold |=> overrun);

  // R6
  status_match_chk: assert property (@(posedge clk) disable iff (rst)
    buf_status == (msg_count != '0));

  // R7
  int_gate_chk: assert property (@(posedge clk) disable iff (rst)
    !rx_int_en |-> !rx_int);

  // R8
  hold_clear_chk: assert property (@(posedge clk) disable iff (rst)
    ctl_hold |=> (msg_count == '0) && !buf_status && !overrun);

  // R10
  discard_chk: assert property (@(posedge clk) disable iff (rst)
    wr_end && !wr_keep && !overrun && !ctl_hold |=>
      !overrun && (msg_count <= $past(msg_count)));
endmodule

bind can_rx_store can_rxs_chk #(.DEPTH(DEPTH), .MSG_W(MSG_W), .CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst(rst), .ctl_hold(ctl_hold), .cmd_clr_ovr(cmd_clr_ovr),
  .rx_int_en(rx_int_en), .wr_end(wr_end), .wr_keep(wr_keep),
  .msg_count(msg_count), .buf_status(buf_status), .overrun(overrun),
  .rx_int(rx_int), .used_bytes(used_q)
);

// File: tb/can_rx_store_tb.sv
`timescale 1ns/1ps
module can_rx_store_tb;
  localparam int DEPTH = 64;
  localparam int MSG_W = 5;

  logic clk = 1'b0;
  logic rst, ctl_hold, wr_valid, wr_sof, wr_end, wr_keep;
  logic cmd_release, cmd_clr_ovr, rx_int_en;
  logic [7:0] wr_data, rd_data;
  logic [4:0] rd_addr;
  logic [MSG_W-1:0] msg_count;
  logic buf_status, overrun, rx_int;

  always #4 clk = ~clk;

  can_rx_store u_dut (
    .clk(clk), .rst(rst), .ctl_hold(ctl_hold),
    .wr_valid(wr_valid), .wr_sof(wr_sof), .wr_data(wr_data),
    .wr_end(wr_end), .wr_keep(wr_keep),
    .rd_addr(rd_addr), .rd_data(rd_data),
    .cmd_release(cmd_release), .cmd_clr_ovr(cmd_clr_ovr), .rx_int_en(rx_int_en),
    .msg_count(msg_count), .buf_status(buf_status), .overrun(overrun), .rx_int(rx_int)
  );

  int n_chk = 0;
  int n_fail = 0;
  bit finished = 1'b0;
  logic [7:0] mq[$];
  int lq[$];
  bit exp_ovr = 1'b0;

  function automatic int flen(logic [7:0] info);
    int d;
    d = info[6] ? 0 : ((int'(info[3:0]) > 8) ? 8 : int'(info[3:0]));
    return (info[7] ? 5 : 3) + d;
  endfunction

  function automatic int used_sum();
    int s = 0;
    foreach (lq[i]) s += lq[i];
    return s;
  endfunction

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic mk(input logic [7:0] info, input int seed, output logic [7:0] fr[$]);
    fr = {};
    fr.push_back(info);
    for (int k = 1; k <= flen(info) + 1; k++) fr.push_back(8'(seed * 13 + k * 29));
  endtask

  task automatic send(input logic [7:0] fr[$], input bit keep, input bit clr_end);
    int need;
    bit dropped;
    dropped = 1'b0;
    foreach (fr[i]) begin
      @(negedge clk);
      wr_valid = 1'b1; wr_sof = (i == 0); wr_data = fr[i];
    end
    @(negedge clk);
    wr_valid = 1'b0; wr_sof = 1'b0;
    wr_end = 1'b1; wr_keep = keep; cmd_clr_ovr = clr_end;
    @(negedge clk);
    wr_end = 1'b0; wr_keep = 1'b0; cmd_clr_ovr = 1'b0;
    if (!ctl_hold && keep) begin
      need = flen(fr[0]);
      if (need <= DEPTH - used_sum()) begin
        lq.push_back(need);
        for (int k = 0; k < need; k++) mq.push_back(fr[k]);
      end else begin
        exp_ovr = 1'b1; dropped = 1'b1;
      end
    end
    if (clr_end && !dropped) exp_ovr = 1'b0;
  endtask

  task automatic send_info(input logic [7:0] info, input int seed, input bit keep, input bit clr_end);
    logic [7:0] fr[$];
    mk(info, seed, fr);
    send(fr, keep, clr_end);
  endtask

  task automatic rd(input int a, output logic [7:0] v);
    @(negedge clk);
    rd_addr = 5'(a);
    @(negedge clk);
    v = rd_data;
  endtask

  // R3: window reads the oldest frame; addresses outside it return zero.
  task automatic check_head(string req);
    logic [7:0] v;
    if (lq.size() == 0) return;
    for (int a = 16; a <= 28; a++) begin
      if (a - 16 < lq[0]) begin
        rd(a, v);
        check(req, v, mq[a - 16]);
      end
    end
    rd(29, v); check("R3", v, 0);
    rd(5, v);  check("R3", v, 0);
  endtask

  task automatic release_cmd();
    @(negedge clk); cmd_release = 1'b1;
    @(negedge clk); cmd_release = 1'b0;
    if (!ctl_hold && lq.size() > 0) begin
      repeat (lq[0]) void'(mq.pop_front());
      void'(lq.pop_front());
    end
  endtask

  task automatic clr_ovr();
    @(negedge clk); cmd_clr_ovr = 1'b1;
    @(negedge clk); cmd_clr_ovr = 1'b0;
    exp_ovr = 1'b0;
  endtask

  task automatic check_status(string req);
    check({req, " count"},    msg_count, lq.size());
    check({"R6 ", req},       buf_status, lq.size() > 0);
    check({req, " overrun"},  overrun, exp_ovr);
    check({"R7 ", req},       rx_int, (lq.size() > 0) && rx_int_en);
  endtask

  initial begin
    #(8 * 150000);
    if (!finished) begin
      n_fail++;
      $display("FAIL watchdog actual=running expected=done");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    rst = 1'b1; ctl_hold = 1'b0; wr_valid = 1'b0; wr_sof = 1'b0; wr_end = 1'b0;
    wr_keep = 1'b0; cmd_release = 1'b0; cmd_clr_ovr = 1'b0; rx_int_en = 1'b1;
    wr_data = '0; rd_addr = '0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check_status("R12");
    check("R12 rd_data", rd_data, 0);

    // Sweep every info byte variant ahead of a fixed follower (R2, R9, R11).
    for (int c = 0; c < 64; c++) begin
      logic [7:0] info;
      info = {c[5], c[4], 2'b00, c[3:0]};
      send_info(info, c, 1'b1, 1'b0);
      send_info(8'h02, c + 100, 1'b1, 1'b0);
      check_status("R4");
      check_head("R2 R11");
      release_cmd();
      check_head("R9");
      release_cmd();
      check_status("R4");
    end

    // Exact fill to 64 bytes (R1), then one small frame too many (R5).
    for (int i = 0; i < 4; i++) send_info(8'h88, 200 + i, 1'b1, 1'b0);
    send_info(8'h87, 210, 1'b1, 1'b0);
    check_status("R1");
    send_info(8'h40, 211, 1'b1, 1'b0);
    check_status("R5");
    check_head("R5");
    clr_ovr();
    check_status("R5");
    send_info(8'h40, 212, 1'b0, 1'b0);
    check_status("R10");
    send_info(8'h40, 213, 1'b1, 1'b1);
    check_status("R5");
    clr_ovr();
    for (int i = 0; i < 5; i++) begin
      check_head("R9");
      release_cmd();
    end
    check_status("R4");

    // Release with nothing stored (R4).
    release_cmd();
    check_status("R4");
    send_info(8'h08, 220, 1'b1, 1'b0);
    check_head("R4");
    release_cmd();

    // Discarded frame leaves no trace (R10).
    send_info(8'h02, 230, 1'b0, 1'b0);
    check_status("R10");
    send_info(8'h03, 231, 1'b1, 1'b0);
    check_head("R10");
    release_cmd();
    check_status("R10");

    // Interrupt gating (R7).
    send_info(8'h01, 240, 1'b1, 1'b0);
    @(negedge clk); rx_int_en = 1'b0; #1;
    check("R7 disabled", rx_int, 0);
    @(negedge clk); rx_int_en = 1'b1; #1;
    check("R7 enabled", rx_int, 1);
    release_cmd();

    // Hold empties the store and blocks writes and releases (R8).
    for (int i = 0; i < 5; i++) send_info(8'h88, 250 + i, 1'b1, 1'b0);
    check_status("R5");
    @(negedge clk); ctl_hold = 1'b1;
    send_info(8'h02, 260, 1'b1, 1'b0);
    release_cmd();
    @(negedge clk); ctl_hold = 1'b0;
    mq = {}; lq = {}; exp_ovr = 1'b0;
    @(negedge clk);
    check_status("R8");
    send_info(8'hC5, 261, 1'b1, 1'b0);
    check_head("R8");
    release_cmd();
    check_status("R8");

    // Synchronous reset (R12).
    send_info(8'h04, 270, 1'b1, 1'b0);
    @(negedge clk); rst = 1'b1;
    @(negedge clk); rst = 1'b0;
    mq = {}; lq = {}; exp_ovr = 1'b0;
    check_status("R12");

    finished = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule